// File: doc/BRIEF.md
# Radix-Tree Row Select Decoder

This block turns a binary row address into a one-hot row-select vector. It does not use a single wide decode of the full address. The address is cut into fixed-width digit groups of 2 or 4 bits, and each digit is expanded to its own one-hot code. A tree of small selector nodes then spreads the global enable downwards. At each level a node forwards its enable to exactly one of its 4 or 16 children, and the digit of that level picks the child. The enable that reaches a leaf is the row line.

The most significant digit chooses the branch at the root. The least significant digit chooses among the leaves, so the index of the active row equals the address value. No node drives more loads than the radix, whatever the address width. The vector can be taken straight from the tree, or through one output register that is cleared by a synchronous reset.

Top module: `row_tree_decoder`

## Requirements
- R1: While `en` is high, `rows` has exactly one bit set, and that bit is `rows[addr]`, with bit 0 standing for address 0.
- R2: While `en` is low, every bit of `rows` is 0, whatever the value of `addr`.
- R3: With `GRP_W` = 2 (radix 4, four levels for an 8-bit address), all 256 addresses decode as in R1.
- R4: With `GRP_W` = 4 (radix 16, two levels for an 8-bit address), all 256 addresses decode as in R1.
- R5: The top digit picks the root branch. Changing only `addr[7:6]` in the radix-4 build moves the active row by multiples of 64, and changing only the low digit moves it within a group of 4 neighbours.
- R6: With `OUT_MODE` = OUT_REG, `rows` shows the decode of the `en` and `addr` sampled at the previous rising edge of `clk`, and holds that value until the next edge.
- R7: With `OUT_MODE` = OUT_REG, a high `rst` at a rising edge clears `rows` to all zeros, even while `en` is high.
- R8: With `OUT_MODE` = OUT_COMB, `rows` follows `en` and `addr` within the same cycle, with no clock edge in between.
- R9: The extreme addresses 0 and all-ones select row 0 and the top row respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| en | input | 1 | Global enable fed to the root of the tree |
| addr | input | ADDR_W | Binary row address |
| rows | output | 2**ADDR_W | One-hot row-select vector |

## Verification
The bench builds two 8-bit decoders side by side. The first uses 2-bit digits with a registered output, which gives four tree levels and exposes the one-cycle latency and the reset clear. The second uses 4-bit digits with a combinational output, which gives a two-level radix-16 tree whose output can be checked inside the same cycle. Both decoders are swept over every address. A vector table covers the enable gating, digit-position moves and extreme addresses on both radices.

// File: rtl/row_tree_pkg.sv
package row_tree_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // Number of tree levels for a given address and digit width.
    function automatic int unsigned tree_levels(int unsigned aw, int unsigned gw);
        return aw / gw;
    endfunction

    // Number of enable lines leaving level k of the tree.
    function automatic int unsigned level_width(int unsigned gw, int unsigned k);
        return 1 << (gw * (k + 1));
    endfunction

    function automatic bit legal_digit(int unsigned gw);
        return (gw == 2) || (gw == 4);
    endfunction

endpackage

// File: rtl/digit_onehot.sv
module digit_onehot #(
    parameter int unsigned GW = 2,
    localparam int unsigned FAN = 1 << GW
) (
    input  logic [GW-1:0]  code,
    output logic [FAN-1:0] oh
);
    always_comb begin
        oh       = '0;
        oh[code] = 1'b1;
    end
endmodule

// File: rtl/select_node.sv
module select_node #(
    parameter int unsigned FAN = 4
) (
    input  logic           up_en,
    input  logic [FAN-1:0] pick,
    output logic [FAN-1:0] down_en
);
    // One node drives only FAN child enables; one child follows up_en.
    assign down_en = pick & {FAN{up_en}};
endmodule

// File: rtl/tree_stage.sv
module tree_stage #(
    parameter int unsigned PARENTS = 1,
    parameter int unsigned FAN     = 4
) (
    input  logic [PARENTS-1:0]     par_en,
    input  logic [FAN-1:0]         pick,
    output logic [PARENTS*FAN-1:0] kid_en
);
    for (genvar p = 0; p < PARENTS; p++) begin : g_node
        select_node #(.FAN(FAN)) u_node (
            .up_en  (par_en[p]),
            .pick   (pick),
            .down_en(kid_en[p*FAN +: FAN])
        );
    end
endmodule

// File: rtl/row_tree_decoder.sv
module row_tree_decoder
    import row_tree_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned GRP_W    = 2,
    parameter out_mode_e   OUT_MODE = OUT_REG,
    localparam int unsigned ROWS    = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROWS-1:0]   rows
);
    localparam int unsigned FAN    = 1 << GRP_W;
    localparam int unsigned LEVELS = tree_levels(ADDR_W, GRP_W);

    if (!legal_digit(GRP_W)) begin : g_bad_digit
        $error("GRP_W must be 2 or 4");
    end
    if ((ADDR_W % GRP_W) != 0 || ADDR_W == 0) begin : g_bad_width
        $error("ADDR_W must be a non-zero multiple of GRP_W");
    end

    // Digit g = 0 is the most significant group and steers the root.
    logic [LEVELS*FAN-1:0] digit_oh;
    for (genvar g = 0; g < LEVELS; g++) begin : g_digit
        digit_onehot #(.GW(GRP_W)) u_oh (
            .code(addr[ADDR_W-1-g*GRP_W -: GRP_W]),
            .oh  (digit_oh[g*FAN +: FAN])
        );
    end

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int unsigned NKID = level_width(GRP_W, k);
        logic [NKID-1:0] kid;
        if (k == 0) begin : g_root
            tree_stage #(.PARENTS(1), .FAN(FAN)) u_stage (
                .par_en(en),
                .pick  (digit_oh[0 +: FAN]),
                .kid_en(kid)
            );
        end else begin : g_inner
            tree_stage #(.PARENTS(NKID / FAN), .FAN(FAN)) u_stage (
                .par_en(g_lvl[k-1].kid),
                .pick  (digit_oh[k*FAN +: FAN]),
                .kid_en(kid)
            );
        end
    end

    logic [ROWS-1:0] rows_d;
    assign rows_d = g_lvl[LEVELS-1].kid;

    if (OUT_MODE == OUT_REG) begin : g_reg
        logic [ROWS-1:0] rows_q;
        always_ff @(posedge clk) begin
            if (rst) rows_q <= '0;
            else     rows_q <= rows_d;
        end
        assign rows = rows_q;
    end else begin : g_comb
        assign rows = rows_d;
    end
endmodule

// File: rtl/row_tree_checker.sv
module row_tree_checker
    import row_tree_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter out_mode_e   OUT_MODE = OUT_REG,
    localparam int unsigned ROWS    = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [ADDR_W-1:0] addr,
    input logic [ROWS-1:0]   rows
);
    assert_never_multi_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rows));

    if (OUT_MODE == OUT_REG) begin : g_reg_chk
        assert_hit_row_R6: assert property (@(posedge clk) disable iff (rst)
            en |=> (rows[$past(addr)] && $countones(rows) == 1));
        assert_off_zero_R2: assert property (@(posedge clk) disable iff (rst)
            !en |=> (rows == '0));
        assert_reset_clear_R7: assert property (@(posedge clk)
            rst |=> (rows == '0));
    end else begin : g_comb_chk
        assert_hit_row_R8: assert property (@(posedge clk) disable iff (rst)
            en |-> (rows[addr] && $countones(rows) == 1));
        assert_off_zero_R2: assert property (@(posedge clk) disable iff (rst)
            !en |-> (rows == '0));
    end
endmodule

bind row_tree_decoder row_tree_checker #(
    .ADDR_W  (ADDR_W),
    .OUT_MODE(OUT_MODE)
) u_chk (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .addr(addr),
    .rows(rows)
);

// File: tb/row_tree_decoder_bench.sv
`timescale 1ns/1ps
module row_tree_decoder_bench;
    import row_tree_pkg::*;

    localparam int unsigned AW   = 8;
    localparam int unsigned ROWS = 1 << AW;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } vec_t;

    localparam int unsigned NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h00}, '{1'b1, 8'hFF}, '{1'b0, 8'h5A}, '{1'b1, 8'h40},
        '{1'b1, 8'h80}, '{1'b1, 8'hC0}, '{1'b1, 8'hC1}, '{1'b1, 8'hC3},
        '{1'b0, 8'hFF}, '{1'b1, 8'h11}, '{1'b1, 8'hA5}, '{1'b0, 8'h00}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en  = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [ROWS-1:0] rows_r4;
    logic [ROWS-1:0] rows_r16;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    row_tree_decoder #(.ADDR_W(AW), .GRP_W(2), .OUT_MODE(OUT_REG)) u_row_tree_decoder (
        .clk(clk), .rst(rst), .en(en), .addr(addr), .rows(rows_r4)
    );

    row_tree_decoder #(.ADDR_W(AW), .GRP_W(4), .OUT_MODE(OUT_COMB)) u_row_tree_decoder_r16 (
        .clk(clk), .rst(rst), .en(en), .addr(addr), .rows(rows_r16)
    );

    function automatic logic [ROWS-1:0] expect_rows(logic e, logic [AW-1:0] a);
        logic [ROWS-1:0] v;
        v    = '0;
        v[a] = e;
        return v;
    endfunction

    task automatic check(string req, logic [ROWS-1:0] act, logic [ROWS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R7: reset held with enable high keeps registered rows cleared
        @(negedge clk);
        en = 1'b1; addr = 8'h37;
        @(posedge clk); #1;
        check("R7 reset clears registered rows", rows_r4, '0);
        @(negedge clk);
        rst = 1'b0;

        // Vector table on both radices
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            en   = VECS[i].en;
            addr = VECS[i].addr;
            #1;
            check(VECS[i].en ? "R8 R4 radix16 same-cycle decode" : "R2 R8 disabled radix16",
                  rows_r16, expect_rows(VECS[i].en, VECS[i].addr));
            @(posedge clk); #1;
            check(VECS[i].en ? "R1 R5 R9 radix4 decode" : "R2 disabled radix4",
                  rows_r4, expect_rows(VECS[i].en, VECS[i].addr));
        end

        // R5: only the top digit differs, so the row moves by 192
        @(negedge clk); en = 1'b1; addr = 8'h02;
        @(posedge clk); #1;
        check("R5 low root branch", rows_r4, ROWS'(1) << 2);
        @(negedge clk); addr = 8'hC2;
        @(posedge clk); #1;
        check("R5 top digit moves row by 192", rows_r4, ROWS'(1) << 194);

        // R6: new input mid-cycle does not reach registered rows before the edge
        @(negedge clk); addr = 8'h09;
        #1;
        check("R6 registered holds previous decode", rows_r4, ROWS'(1) << 194);
        check("R8 comb follows at once", rows_r16, ROWS'(1) << 9);
        @(posedge clk); #1;
        check("R6 registered updates after edge", rows_r4, ROWS'(1) << 9);

        // R9: extreme addresses
        @(negedge clk); addr = '1;
        @(posedge clk); #1;
        check("R9 all-ones selects top row", rows_r4, ROWS'(1) << (ROWS - 1));
        @(negedge clk); addr = '0;
        @(posedge clk); #1;
        check("R9 zero selects row 0", rows_r4, ROWS'(1));

        // R3, R4: full sweep on both builds
        for (int a = 0; a < ROWS; a++) begin
            @(negedge clk);
            en = 1'b1; addr = AW'(a);
            #1;
            check("R4 radix16 sweep", rows_r16, expect_rows(1'b1, AW'(a)));
            @(posedge clk); #1;
            check("R3 radix4 sweep", rows_r4, expect_rows(1'b1, AW'(a)));
        end

        // R2: enable low across several addresses
        for (int a = 0; a < ROWS; a += 37) begin
            @(negedge clk);
            en = 1'b0; addr = AW'(a);
            #1;
            check("R2 disabled radix16", rows_r16, '0);
            @(posedge clk); #1;
            check("R2 disabled radix4", rows_r4, '0);
        end

        // R7: reset after activity clears the registered output
        @(negedge clk); en = 1'b1; addr = 8'h77;
        @(posedge clk); #1;
        check("R1 before reset", rows_r4, ROWS'(1) << 8'h77);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R7 reset clears after activity", rows_r4, '0);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule